// File: doc/BRIEF.md
# Card Data Path Controller

This block sequences one block-oriented data transfer between a byte FIFO and the data lines of a memory card. Software programs a total byte count, a wait limit counted in card-clock periods, an interrupt mask, and finally a control word that carries an enable bit, a direction bit and a block-size exponent. The control word write launches the transfer. The controller then waits for each block to begin on the card side, moves one byte per card-clock strobe while the FIFO can take or give a byte, and waits for the line layer to report the end of the block together with its CRC result.

Bit-level line driving and CRC16 generation are outside the block. The line layer reports them to the controller through three inputs: a block-start indication, a block-complete strobe and a CRC-good flag. Block completion, transfer completion, CRC failure and expiry of the wait limit are latched into sticky status bits. A masked OR of these bits drives the interrupt line.

Top module: `card_dpath`

## Requirements
- R1: After a synchronous reset, `status` is 0, `irq` is 0, `busy` is 0, and neither `fifo_push` nor `fifo_pop` is asserted.
- R2: Register addresses are 0 = control, 1 = byte length, 2 = wait limit, 3 = interrupt mask, 4 = status clear. In the control word, bit 0 is the enable bit and bit 1 is the direction bit (1 = card to host, bytes pushed into the FIFO; 0 = host to card, bytes popped from the FIFO). Bits [7:4] give the block size as a power-of-two exponent, so the block is 2^exp bytes. Any exponent above 11 is treated as 11, which is 2048 bytes.
- R3: While a block is being moved, each card strobe that finds the FIFO ready (`fifo_space` for direction 1, `fifo_avail` for direction 0) moves one byte. The matching `fifo_push` or `fifo_pop` pulses for one cycle, in the cycle after the strobe is sampled. A strobe that finds the FIFO not ready moves nothing.
- R4: A block ends after block-size bytes, or earlier when the remaining length runs out (a short last block). The controller then waits for `blk_done`. If `crc_ok` is set with it, status bit 0 (block end) is set.
- R5: When the last block ends with a good CRC, status bit 1 (data end) is set together with bit 0, and `busy` falls one cycle later. A transfer started with a length of 0 sets data end at the control write itself.
- R6: `blk_done` with `crc_ok` low sets status bit 2 (CRC fail), does not set data end, and returns the controller to idle at once.
- R7: The wait counter loads the wait limit T each time the controller starts to wait for a block. Each card strobe spent waiting for the card (before the block start, or before block completion) counts down. On the T-th such strobe (the first one if T is 0 or 1), status bit 3 (timeout) is set and the controller returns to idle.
- R8: Writing the control word with the enable bit clear aborts the transfer at once. After that, no further byte moves and no status events occur.
- R9: Status bits are sticky. Writing ones to the clear address clears the matching bits. An event in the same cycle as a clear of its bit leaves the bit set.
- R10: `irq` is the OR of `status & mask`. It is updated in the same cycle as `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| card_stb | input | 1 | One-cycle pulse per card-clock period |
| card_sof | input | 1 | Line layer has seen the start of a block |
| blk_done | input | 1 | Line layer has finished the block CRC phase |
| crc_ok | input | 1 | CRC result accompanying `blk_done` |
| fifo_space | input | 1 | FIFO can accept a byte |
| fifo_avail | input | 1 | FIFO holds a byte |
| fifo_push | output | 1 | One byte written into the FIFO |
| fifo_pop | output | 1 | One byte taken from the FIFO |
| busy | output | 1 | A transfer is in progress |
| status | output | 4 | Sticky events: block end, data end, CRC fail, timeout |
| irq | output | 1 | Masked interrupt |

## Verification
Each result has a known due cycle. Register writes, `card_sof`, `blk_done` and the strobe that completes a wait take effect at the clock edge that samples them, so `status`, `irq` and `busy` are due right after that edge. The exception is the fall of `busy` after a data end, which comes one edge later. A FIFO push or pop is due in the cycle after its strobe. The driver changes inputs shortly after each rising edge and queues the expected value. The monitor compares it at the following falling edge, so every comparison lands in the cycle where the result is due, with no overlap with an edge.

// File: rtl/card_dpath_pkg.sv
package card_dpath_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_START, S_XFER, S_CHECK_CRC, S_DONE
  } dp_state_e;

  localparam int NUM_EV  = 4;
  localparam int EV_BLK  = 0;
  localparam int EV_END  = 1;
  localparam int EV_CRC  = 2;
  localparam int EV_TMO  = 3;

  localparam int ADDR_W  = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_LEN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TMO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd4;

  localparam int EXP_W = 4;
endpackage

// File: rtl/card_dpath_timer.sv
module card_dpath_timer #(
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TMO_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [TMO_W-1:0] cnt_q;

  assign expire = tick && (cnt_q <= TMO_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (tick && !expire) cnt_q <= cnt_q - TMO_W'(1);
  end

  // R7: the count only changes on a load or a tick
  a_r7_count_holds: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/card_dpath_regs.sv
module card_dpath_regs
  import card_dpath_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int TMO_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TMO_W-1:0]  wdata,
  input  logic [NUM_EV-1:0] evt,
  output logic              start,
  output logic              abort,
  output logic              dir,
  output logic [EXP_W-1:0]  exp_f,
  output logic [LEN_W-1:0]  len,
  output logic [TMO_W-1:0]  tmo,
  output logic [NUM_EV-1:0] status,
  output logic              irq
);
  logic [NUM_EV-1:0] mask_q, mask_d, clr_vec, status_d;

  assign start   = we && (addr == A_CTRL) &&  wdata[0];
  assign abort   = we && (addr == A_CTRL) && !wdata[0];
  assign clr_vec = (we && addr == A_CLR) ? wdata[NUM_EV-1:0] : '0;
  assign mask_d  = (we && addr == A_MASK) ? wdata[NUM_EV-1:0] : mask_q;
  assign status_d = (status & ~clr_vec) | evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir    <= 1'b0;
      exp_f  <= '0;
      len    <= '0;
      tmo    <= '0;
      mask_q <= '0;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      if (we && addr == A_CTRL) begin
        dir   <= wdata[1];
        exp_f <= wdata[7:4];
      end
      if (we && addr == A_LEN) len <= wdata[LEN_W-1:0];
      if (we && addr == A_TMO) tmo <= wdata;
      mask_q <= mask_d;
      status <= status_d;
      irq    <= |(status_d & mask_d);
    end
  end

  // R9: a set bit survives every cycle that does not clear it
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(status & ~clr_vec)) == $past(status & ~clr_vec)));
  // R10: no interrupt without a masked status bit
  a_r10_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> (status != '0));
endmodule

// File: rtl/card_dpath_fsm.sv
module card_dpath_fsm
  import card_dpath_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int TMO_W   = 32,
  parameter int MAX_EXP = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic              dir,
  input  logic [EXP_W-1:0]  exp_f,
  input  logic [LEN_W-1:0]  len,
  input  logic [TMO_W-1:0]  tmo,
  input  logic              card_stb,
  input  logic              card_sof,
  input  logic              blk_done,
  input  logic              crc_ok,
  input  logic              fifo_space,
  input  logic              fifo_avail,
  output logic [NUM_EV-1:0] evt,
  output logic              busy,
  output logic              push,
  output logic              pop
);
  localparam int BLK_W = MAX_EXP + 1;
  localparam int CW    = (LEN_W > BLK_W) ? LEN_W : BLK_W;

  dp_state_e        state_q, state_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [BLK_W-1:0] blk_q, blk_d, blk_bytes;
  logic [EXP_W-1:0] exp_eff;
  logic [CW-1:0]    chunk;
  logic             move, fifo_rdy, tmr_load, tick, expire;

  assign exp_eff   = (exp_f > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_f;
  assign blk_bytes = BLK_W'(1) << exp_eff;
  assign chunk     = (CW'(blk_bytes) < CW'(rem_q)) ? CW'(blk_bytes) : CW'(rem_q);
  assign fifo_rdy  = dir ? fifo_space : fifo_avail;

  card_dpath_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmo),
    .tick(tick), .expire(expire)
  );

  always_comb begin
    state_d  = state_q;
    rem_d    = rem_q;
    blk_d    = blk_q;
    evt      = '0;
    move     = 1'b0;
    tmr_load = 1'b0;
    tick     = 1'b0;
    case (state_q)
      S_WAIT_START: begin
        if (card_sof) begin
          state_d = S_XFER;
          blk_d   = BLK_W'(chunk);
        end else if (card_stb) begin
          tick = 1'b1;
          if (expire) begin
            evt[EV_TMO] = 1'b1;
            state_d     = S_IDLE;
          end
        end
      end
      S_XFER: begin
        if (card_stb && fifo_rdy) begin
          move  = 1'b1;
          rem_d = rem_q - LEN_W'(1);
          blk_d = blk_q - BLK_W'(1);
          if (blk_q == BLK_W'(1)) state_d = S_CHECK_CRC;
        end
      end
      S_CHECK_CRC: begin
        if (blk_done) begin
          if (crc_ok) begin
            evt[EV_BLK] = 1'b1;
            if (rem_q == '0) begin
              evt[EV_END] = 1'b1;
              state_d     = S_DONE;
            end else begin
              state_d  = S_WAIT_START;
              tmr_load = 1'b1;
            end
          end else begin
            evt[EV_CRC] = 1'b1;
            state_d     = S_IDLE;
          end
        end else if (card_stb) begin
          tick = 1'b1;
          if (expire) begin
            evt[EV_TMO] = 1'b1;
            state_d     = S_IDLE;
          end
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (abort) begin
      state_d = S_IDLE;
      evt     = '0;
      move    = 1'b0;
    end else if (start) begin
      evt   = '0;
      move  = 1'b0;
      rem_d = len;
      if (len == '0) begin
        evt[EV_END] = 1'b1;
        state_d     = S_DONE;
      end else begin
        state_d  = S_WAIT_START;
        tmr_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      rem_q   <= '0;
      blk_q   <= '0;
      push    <= 1'b0;
      pop     <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      blk_q   <= blk_d;
      push    <= move && dir;
      pop     <= move && !dir;
    end
  end

  assign busy = (state_q != S_IDLE);

  // R3: bytes move only while a block is in flight
  a_r3_move_in_xfer: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_XFER) |=> !(push || pop));
  // R2: push and pop never together
  a_r2_one_direction: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
  // R4: a block in flight always has bytes left
  a_r4_block_nonzero: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_XFER) |-> (blk_q != '0));
endmodule

// File: rtl/card_dpath.sv
module card_dpath
  import card_dpath_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int TMO_W   = 32,
  parameter int MAX_EXP = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              card_stb,
  input  logic              card_sof,
  input  logic              blk_done,
  input  logic              crc_ok,
  input  logic              fifo_space,
  input  logic              fifo_avail,
  output logic              fifo_push,
  output logic              fifo_pop,
  output logic              busy,
  output logic [3:0]        status,
  output logic              irq
);
  logic              start, abort, dir;
  logic [EXP_W-1:0]  exp_f;
  logic [LEN_W-1:0]  len;
  logic [TMO_W-1:0]  tmo;
  logic [NUM_EV-1:0] evt;

  card_dpath_regs #(.LEN_W(LEN_W), .TMO_W(TMO_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
    .wdata(TMO_W'(cfg_wdata)), .evt(evt), .start(start), .abort(abort),
    .dir(dir), .exp_f(exp_f), .len(len), .tmo(tmo),
    .status(status), .irq(irq)
  );

  card_dpath_fsm #(.LEN_W(LEN_W), .TMO_W(TMO_W), .MAX_EXP(MAX_EXP)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .dir(dir),
    .exp_f(exp_f), .len(len), .tmo(tmo), .card_stb(card_stb),
    .card_sof(card_sof), .blk_done(blk_done), .crc_ok(crc_ok),
    .fifo_space(fifo_space), .fifo_avail(fifo_avail), .evt(evt),
    .busy(busy), .push(fifo_push), .pop(fifo_pop)
  );
endmodule

// File: tb/card_dpath_tb.sv
module card_dpath_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        card_stb = 1'b0, card_sof = 1'b0, blk_done = 1'b0, crc_ok = 1'b0;
  logic        fifo_space = 1'b1, fifo_avail = 1'b1;
  logic        fifo_push, fifo_pop, busy, irq;
  logic [3:0]  status;

  always #2.5 clk = ~clk;

  card_dpath u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .card_stb(card_stb), .card_sof(card_sof),
    .blk_done(blk_done), .crc_ok(crc_ok), .fifo_space(fifo_space),
    .fifo_avail(fifo_avail), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
    .busy(busy), .status(status), .irq(irq)
  );

  typedef struct { string tag; int kind; int expv; } item_t;
  item_t sbq[$];
  int compared = 0, mismatched = 0;
  int n_push = 0, n_pop = 0, exp_push = 0, exp_pop = 0;
  bit finished = 1'b0;

  // monitor: count byte moves, then pop and compare queued expectations
  always @(negedge clk) begin
    int act;
    if (!rst) begin
      if (fifo_push) n_push++;
      if (fifo_pop)  n_pop++;
    end
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      case (it.kind)
        0: act = int'(status);
        1: act = int'(irq);
        2: act = int'(busy);
        3: act = n_push;
        default: act = n_pop;
      endcase
      compared++;
      if (act != it.expv) begin
        mismatched++;
        $display("FAIL %s: actual %0d expected %0d", it.tag, act, it.expv);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic expect_v(string tag, int kind, int expv);
    item_t it;
    it.tag = tag; it.kind = kind; it.expv = expv;
    sbq.push_back(it);
  endtask
  task automatic wr(logic [2:0] a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask
  task automatic strobes(int n);
    for (int i = 0; i < n; i++) begin
      card_stb = 1'b1; step(); card_stb = 1'b0; step();
    end
  endtask
  task automatic sof();
    card_sof = 1'b1; step(); card_sof = 1'b0;
  endtask
  task automatic bdone(logic ok);
    blk_done = 1'b1; crc_ok = ok; step(); blk_done = 1'b0; crc_ok = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    expect_v("R1 status", 0, 0); expect_v("R1 irq", 1, 0); expect_v("R1 busy", 2, 0);

    // R2 R3 R4 R5: card-to-host, 8 bytes in 4-byte blocks
    wr(3'd1, 8); wr(3'd2, 100); wr(3'd3, 'hF); wr(3'd0, 'h23);
    expect_v("R2 busy after start", 2, 1);
    sof(); strobes(4); bdone(1);
    expect_v("R4 block end", 0, 1);
    exp_push += 4; expect_v("R3 push count", 3, exp_push);
    sof(); strobes(4); bdone(1);
    expect_v("R5 data end", 0, 3); expect_v("R10 irq", 1, 1); expect_v("R5 busy hold", 2, 1);
    step();
    expect_v("R5 busy falls", 2, 0);
    exp_push += 4; expect_v("R3 push total", 3, exp_push);
    expect_v("R2 no pop on read", 4, exp_pop);

    // R9 clear, then host-to-card with stall and short last block
    wr(3'd4, 'hF);
    expect_v("R9 clear", 0, 0); expect_v("R10 irq clear", 1, 0);
    wr(3'd1, 5); wr(3'd0, 'h21);
    sof(); fifo_avail = 1'b0; strobes(2);
    expect_v("R3 stall no pop", 4, exp_pop);
    fifo_avail = 1'b1; strobes(4); bdone(1);
    expect_v("R4 first block", 0, 1);
    sof(); strobes(1); bdone(1);
    expect_v("R4 short last block", 0, 3);
    exp_pop += 5; expect_v("R3 pop total", 4, exp_pop);
    expect_v("R2 no push on write", 3, exp_push);
    step();

    // R6 CRC fail
    wr(3'd4, 'hF); wr(3'd1, 4); wr(3'd0, 'h23);
    sof(); strobes(4); bdone(0);
    expect_v("R6 crc fail", 0, 4); expect_v("R6 idle", 2, 0);
    exp_push += 4;

    // R7 timeout on the third strobe
    wr(3'd4, 'hF); wr(3'd2, 3); wr(3'd1, 8); wr(3'd0, 'h23);
    strobes(2);
    expect_v("R7 not yet", 0, 0); expect_v("R7 still busy", 2, 1);
    strobes(1);
    expect_v("R7 timeout", 0, 8); expect_v("R7 idle", 2, 0);

    // R8 abort
    wr(3'd4, 'hF); wr(3'd2, 100); wr(3'd0, 'h23);
    sof(); strobes(2);
    wr(3'd0, 0);
    expect_v("R8 idle", 2, 0);
    strobes(3);
    exp_push += 2; expect_v("R8 no more moves", 3, exp_push);
    expect_v("R8 no events", 0, 0);

    // R5 zero length
    wr(3'd1, 0); wr(3'd0, 'h23);
    expect_v("R5 zero length end", 0, 2);
    step();
    expect_v("R5 zero length idle", 2, 0);

    // R10 mask
    expect_v("R10 irq masked in", 1, 1);
    wr(3'd3, 1);
    expect_v("R10 irq masked out", 1, 0);
    wr(3'd3, 2);
    expect_v("R10 irq back", 1, 1);

    // R9 set wins over clear
    wr(3'd4, 'hF); wr(3'd2, 1); wr(3'd1, 8); wr(3'd0, 'h23);
    card_stb = 1'b1; cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 8;
    step();
    card_stb = 1'b0; cfg_we = 1'b0;
    expect_v("R9 set beats clear", 0, 8);

    // R2 exponent clamp to 2048-byte blocks
    wr(3'd4, 'hF); wr(3'd2, 100); wr(3'd1, 2049); wr(3'd0, 'hF3);
    sof(); strobes(2048); bdone(1);
    expect_v("R2 clamp block end only", 0, 1);
    sof(); strobes(1); bdone(1);
    expect_v("R2 clamp data end", 0, 3);
    exp_push += 2049; expect_v("R2 clamp push total", 3, exp_push);

    repeat (3) step();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule